// File: doc/BRIEF.md
# High-Window ROM Socket Decoder

This block sits on an 8-bit processor bus and picks one of eight ROM sockets that share the top 16 KB of a 16-bit memory space. The middle address bits that choose the socket are captured in a strobe-controlled holding register. A one-of-eight decoder turns them into active-low chip selects. The two highest address bits are used live as a window qualifier: outside the window no socket is selected.

The block also makes an active-low enable for the ROM data buffer. The buffer drives the shared data bus only when the window is hit and both the bus read strobe and the memory-read status are active. A reset synchronizer gives an asynchronous assertion and a clocked release. During reset and its release cycles every output is held inactive.

Top module: `rom_bank_sel`

## Requirements
- R1: While `rst_n` is low, and for two clock edges after it rises, `cs_n` is all ones and `bus_oe_n` is high.
- R2: `cs_n` is all ones whenever `addr[15:14]` is not `2'b11`.
- R3: On a rising clock edge with `addr_stb` high, the socket index register loads `addr[13:11]`. With `addr_stb` low at that edge it keeps its value.
- R4: When `addr[15:14]` is `2'b11`, exactly one bit `cs_n[k]` is low, where k is the held index as an unsigned number. Index 0 (window bytes 0 to 2 KB) drives `cs_n[0]` and index 7 drives `cs_n[7]`.
- R5: `bus_oe_n` is low when `addr[15:14]` is `2'b11` and both `rd_stb` and `mem_rd` are high.
- R6: With the window qualifier false, no chip select is low, whatever value the index register holds.
- R7: `bus_oe_n` is high whenever `rd_stb` or `mem_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Memory address bus |
| addr_stb | input | 1 | Index capture strobe, active high |
| rd_stb | input | 1 | Bus read strobe, active high |
| mem_rd | input | 1 | Memory-read status, active high |
| cs_n | output | 8 | Active-low socket selects, bit k for socket k |
| bus_oe_n | output | 1 | Active-low ROM data buffer enable |

## Verification
The index register takes effect at the first rising edge on which the strobe is sampled high. The window qualifier and both read strobes reach the outputs with no register in the path. So a change in a selected socket is due one edge after the stimulus, while a change caused by the qualifier or a strobe is due right away. The bench drives each vector on a falling edge and samples at the next falling edge, with exactly one rising edge in between, so that both paths have settled. Reset is checked while it is held, and again after the two synchronizer edges following its release.

// File: rtl/rom_bank_sel_pkg.sv
package rom_bank_sel_pkg;
  localparam int unsigned ADDR_W_DEF  = 16;
  localparam int unsigned SOCK_N_DEF  = 8;
  localparam int unsigned WIN_BITS    = 2;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/rbs_rst_sync.sv
module rbs_rst_sync #(
  parameter int unsigned STAGES = rom_bank_sel_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ok = sync_q[STAGES-1];
endmodule

// File: rtl/rbs_idx_hold.sv
module rbs_idx_hold #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] hold_q;
  logic [W-1:0] hold_d;

  // next-state: capture while strobe is high, otherwise keep
  always_comb begin
    hold_d = hold_q;
    if (load_en) hold_d = d_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign q_out = hold_q;
endmodule

// File: rtl/rbs_sel_decode.sv
module rbs_sel_decode #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [N-1:0]     sel_n
);
  for (genvar g = 0; g < N; g++) begin : g_sel
    assign sel_n[g] = !(en && (idx == IDX_W'(g)));
  end
endmodule

// File: rtl/rom_bank_sel.sv
module rom_bank_sel #(
  parameter int unsigned ADDR_W = rom_bank_sel_pkg::ADDR_W_DEF,
  parameter int unsigned SOCK_N = rom_bank_sel_pkg::SOCK_N_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              addr_stb,
  input  logic              rd_stb,
  input  logic              mem_rd,
  output logic [SOCK_N-1:0] cs_n,
  output logic              bus_oe_n
);
  localparam int unsigned WIN_W  = rom_bank_sel_pkg::WIN_BITS;
  localparam int unsigned IDX_W  = $clog2(SOCK_N);
  localparam int unsigned IDX_HI = ADDR_W - WIN_W - 1;
  localparam int unsigned IDX_LO = IDX_HI - IDX_W + 1;

  logic             rst_ok;
  logic             win_hit;
  logic [IDX_W-1:0] idx_q;
  logic             dec_en;

  rbs_rst_sync #(.STAGES(rom_bank_sel_pkg::SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  rbs_idx_hold #(.W(IDX_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_ok),
    .load_en (addr_stb),
    .d_in    (addr[IDX_HI:IDX_LO]),
    .q_out   (idx_q)
  );

  assign win_hit = &addr[ADDR_W-1:ADDR_W-WIN_W];
  assign dec_en  = rst_ok && win_hit;

  rbs_sel_decode #(.N(SOCK_N), .IDX_W(IDX_W)) u_dec (
    .en    (dec_en),
    .idx   (idx_q),
    .sel_n (cs_n)
  );

  assign bus_oe_n = !(dec_en && rd_stb && mem_rd);
endmodule

// File: rtl/rom_bank_sel_chk.sv
module rom_bank_sel_chk #(
  parameter int unsigned ADDR_W = rom_bank_sel_pkg::ADDR_W_DEF,
  parameter int unsigned SOCK_N = rom_bank_sel_pkg::SOCK_N_DEF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_ok,
  input logic [ADDR_W-1:0] addr,
  input logic              addr_stb,
  input logic              rd_stb,
  input logic              mem_rd,
  input logic [SOCK_N-1:0] cs_n,
  input logic              bus_oe_n
);
  logic win;
  assign win = &addr[ADDR_W-1:ADDR_W-2];

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |-> (&cs_n && bus_oe_n));

  p_window_gate_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    !win |-> &cs_n);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    ($past(rst_ok) && $past(!addr_stb) && win && $past(win)) |-> $stable(cs_n));

  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    win |-> ($countones(~cs_n) == 1));

  p_oe_on_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (win && rd_stb && mem_rd) |-> !bus_oe_n);

  p_oe_off_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    !(rd_stb && mem_rd) |-> bus_oe_n);
endmodule

bind rom_bank_sel rom_bank_sel_chk #(.ADDR_W(ADDR_W), .SOCK_N(SOCK_N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rst_ok   (rst_ok),
  .addr     (addr),
  .addr_stb (addr_stb),
  .rd_stb   (rd_stb),
  .mem_rd   (mem_rd),
  .cs_n     (cs_n),
  .bus_oe_n (bus_oe_n)
);

// File: tb/rom_bank_sel_tb.sv
module rom_bank_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  // {addr[15:0], addr_stb, rd_stb, mem_rd, exp_cs_n[7:0], exp_oe_n}
  localparam logic [27:0] VEC [NV] = '{
    {16'hF800, 3'b100, 8'h7F, 1'b1},  // R4 socket 7, R7 no read
    {16'hC000, 3'b111, 8'hFE, 1'b0},  // R4 socket 0, R5
    {16'hE800, 3'b011, 8'hFE, 1'b0},  // R3 hold index 0
    {16'h7800, 3'b111, 8'hFF, 1'b1},  // R6 latch 7 but window off
    {16'hF000, 3'b010, 8'h7F, 1'b1},  // R3 held 7, R7 mem_rd low
    {16'hD000, 3'b101, 8'hFB, 1'b1},  // R4 socket 2, R7 rd_stb low
    {16'hC800, 3'b111, 8'hFD, 1'b0},  // R4 socket 1, R5
    {16'hBFFF, 3'b111, 8'hFF, 1'b1},  // R2 upper bits 10
    {16'hE7FF, 3'b111, 8'hEF, 1'b0},  // R4 socket 4
    {16'h0000, 3'b011, 8'hFF, 1'b1}   // R2 bottom of map
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic        addr_stb, rd_stb, mem_rd;
  logic [7:0]  cs_n;
  logic        bus_oe_n;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_bank_sel u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .addr_stb(addr_stb),
    .rd_stb(rd_stb), .mem_rd(mem_rd), .cs_n(cs_n), .bus_oe_n(bus_oe_n)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: cs_n/oe_n actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; addr = 16'hFFFF; addr_stb = 1'b1; rd_stb = 1'b1; mem_rd = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset held", {cs_n, bus_oe_n}, 9'h1FF);
    rst_n = 1'b1;
    addr_stb = 1'b0;
    @(negedge clk);
    check("R1 sync release", {cs_n, bus_oe_n}, 9'h1FF);
    @(negedge clk);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {addr, addr_stb, rd_stb, mem_rd} = VEC[i][27:9];
      @(negedge clk);
      check($sformatf("R2-7 vector %0d", i), {cs_n, bus_oe_n}, VEC[i][8:0]);
    end

    // R4 every socket from lowest to highest 2 KB slice
    rd_stb = 1'b0; addr_stb = 1'b1;
    for (int k = 0; k < 8; k++) begin
      addr = 16'hC000 | 16'(k << 11);
      @(negedge clk);
      check($sformatf("R4 socket %0d", k), {cs_n, bus_oe_n}, {~(8'(1) << k), 1'b1});
    end

    // R3 strobe low: new index ignored, held socket 7 visible
    addr_stb = 1'b0; addr = 16'hC000;
    @(negedge clk);
    check("R3 hold ignores new bits", {cs_n, bus_oe_n}, {8'h7F, 1'b1});

    // R6 then window back on restores same held socket
    addr = 16'h4000;
    @(negedge clk);
    check("R6 window off", {cs_n, bus_oe_n}, 9'h1FF);
    addr = 16'hFFFF;
    @(negedge clk);
    check("R3 held after window off", {cs_n, bus_oe_n}, {8'h7F, 1'b1});

    // R1 mid-run asynchronous reset
    rd_stb = 1'b1; mem_rd = 1'b1;
    #1 rst_n = 1'b0;
    #1 check("R1 async assert", {cs_n, bus_oe_n}, 9'h1FF);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 held after release", {cs_n, bus_oe_n}, 9'h1FF);
    @(negedge clk);
    @(negedge clk);
    check("R1 index cleared by reset", {cs_n, bus_oe_n}, {8'hFE, 1'b0});

    finish_run();
  end
endmodule